// File: doc/BRIEF.md
# Threshold-Driven Port/Core Byte FIFO Request Controller

This block sits between a word-wide DMA-style port and an internal engine that works on one byte at a time. It holds two 32-byte FIFOs. The inbound FIFO takes 16-bit or 32-bit port words, splits them into bytes and hands them to the engine. The outbound FIFO collects bytes from the engine and packs them back into port words. For each direction the block drives an active-low request, accepts an active-low acknowledge and drives an active-low terminal-count strobe.

Requests follow hysteresis against programmable byte thresholds. The inbound request arms when free space exceeds its threshold and then stays up until a whole word no longer fits. The outbound request arms when the stored bytes exceed its threshold and then stays up until less than a word remains. A command is started with a byte count for the inbound side. The inbound side stops requesting once that many bytes are in. Bytes of the last word that lie beyond the count are dropped, so the next command begins on a word boundary.

When the engine marks its last output byte, the outbound side drains without regard to its threshold. A short final word is padded with filler. A flag reports the short word, and a 2-bit count of its valid bytes is written into a spare byte lane. Acknowledging when no transfer is possible sets a sticky error flag. The reset input is asynchronous on assertion and must be released synchronously to `clk`.

Top module: `dma_bytefifo_ctl`

## Requirements
- R1: While rst_n is low, both requests and both terminal-count outputs are high (inactive), data_err, dst_noalign and core_in_valid are low, and core_out_ready is high.
- R2: The inbound request (src_req_n low) is registered. It arms only while inbound bytes remain to be taken and the free space after the current cycle exceeds cfg_src_thr. Once armed, it stays low while at least one port word (4 bytes if cfg_wide=1, else 2) still fits. The threshold must be at least one word.
- R3: Each inbound transfer (src_ack_n low, bytes remaining, a word fits) takes min(remaining, word) bytes. The rest of that word is dropped. When the remaining count reaches zero, the request rises in the next cycle and further acknowledges store nothing.
- R4: src_tc_n is low while the remaining count is between 1 and one word, and for the one cycle after the final transfer.
- R5: With cfg_big=0 the lowest byte lane (bits 7:0) is first in the byte stream. With cfg_big=1 the highest lane of the active width (bits 31:24 or 15:8) is first. The same order applies when packing outbound words. Lanes above a 16-bit width are driven 0.
- R6: The outbound request arms when the stored count exceeds cfg_dst_thr and is at least one word. Once armed, it stays low while at least one word is stored.
- R7: After the byte flagged core_out_last has been stored, the outbound request stays low, whatever the threshold, until the FIFO is empty. The final transfer may be shorter than a word.
- R8: For a short final outbound word holding n valid bytes, dst_noalign is high. Unused lanes are 0, except bits 1:0 of the most significant unused lane, which carry n. That lane is lane W-1 when cfg_big=0 and lane W-1-n when cfg_big=1.
- R9: dst_tc_n is low while the last-flagged data still has between 1 and one word stored, and for the one cycle after the final transfer.
- R10: An inbound acknowledge while a word does not fit, or an outbound acknowledge while no transfer is possible, sets data_err one cycle later. data_err stays set until cmd_start.
- R11: core_in_last marks a byte that is the only one stored when no inbound bytes remain. core_out_ready is low when the outbound FIFO is full or is draining a finished block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| cfg_wide | input | 1 | 1: 32-bit port words, 0: 16-bit |
| cfg_big | input | 1 | Byte order select |
| cfg_src_thr | input | 5 | Inbound free-space threshold in bytes |
| cfg_dst_thr | input | 5 | Outbound fill threshold in bytes |
| cmd_start | input | 1 | Loads a new inbound byte count, clears data_err |
| cmd_count | input | 16 | Inbound byte count of the command |
| src_req_n | output | 1 | Inbound transfer request, active low |
| src_ack_n | input | 1 | Inbound transfer acknowledge, active low |
| src_data | input | 32 | Inbound port word |
| src_tc_n | output | 1 | Inbound terminal count, active low |
| core_in_byte | output | 8 | Byte toward the engine |
| core_in_valid | output | 1 | core_in_byte is valid |
| core_in_ready | input | 1 | Engine takes the byte |
| core_in_last | output | 1 | Final byte of the command |
| core_out_byte | input | 8 | Byte from the engine |
| core_out_valid | input | 1 | core_out_byte is valid |
| core_out_last | input | 1 | Final byte of the engine's block |
| core_out_ready | output | 1 | Outbound FIFO accepts a byte |
| dst_req_n | output | 1 | Outbound transfer request, active low |
| dst_ack_n | input | 1 | Outbound transfer acknowledge, active low |
| dst_data | output | 32 | Outbound port word |
| dst_tc_n | output | 1 | Outbound terminal count, active low |
| dst_noalign | output | 1 | Final outbound word is short |
| data_err | output | 1 | Sticky transfer error |

## Verification
The bench fills the inbound FIFO with the engine stalled, then releases it. A controller without hysteresis would re-request as soon as one word of space frees up, rather than waiting for space above the threshold. Inbound counts of 7 and 10 bytes check the dropped trailing bytes: a design that kept them would give the engine extra bytes and shift the next command's data. Outbound blocks smaller than the threshold would never drain if the end-of-block override were missing. Short final words in both byte orders expose a misplaced valid-byte code or a wrong lane order. Acknowledges on a full inbound FIFO and an empty outbound FIFO must latch the error and leave the FIFO contents untouched.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
  localparam int PORT_BYTES = 4;

  function automatic logic [2:0] word_bytes(input logic wide);
    return wide ? 3'd4 : 3'd2;
  endfunction

  // lane carrying the byte at stream position pos (mapping is its own inverse)
  function automatic logic [1:0] lane_of(input logic big, input logic [2:0] wb,
                                         input logic [1:0] pos);
    logic [2:0] t;
    t = wb - 3'd1 - {1'b0, pos};
    return big ? t[1:0] : pos;
  endfunction
endpackage

// File: rtl/dbf_src_side.sv
module dbf_src_side
  import dbf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CW    = 16,
  parameter int TW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wide,
  input  logic          big,
  input  logic [TW-1:0] thr,
  input  logic          start,
  input  logic [CW-1:0] start_count,
  input  logic          ack_n,
  input  logic [31:0]   pdata,
  output logic          req_n,
  output logic          tc_n,
  output logic          ovf,
  output logic [7:0]    core_byte,
  output logic          core_valid,
  input  logic          core_ready,
  output logic          core_last
);
  localparam int AW = $clog2(DEPTH);
  localparam int NW = AW + 1;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [NW-1:0] cnt_q, cnt_d, free, free_d;
  logic [CW-1:0] rem_q, rem_d;
  logic          req_q, req_d, hold_q, hold_d;
  logic [2:0]    wb, take, add;
  logic          fits, xfer, pop;

  assign wb   = word_bytes(wide);
  assign free = NW'(DEPTH) - cnt_q;
  assign fits = free >= NW'(wb);
  assign take = (rem_q == '0) ? 3'd0 : ((rem_q < CW'(wb)) ? rem_q[2:0] : wb);
  assign xfer = !ack_n && (rem_q != '0) && fits;
  assign ovf  = !ack_n && !fits;
  assign pop  = (cnt_q != '0) && core_ready;
  assign add  = xfer ? take : 3'd0;

  always_comb begin
    cnt_d  = cnt_q + NW'(add) - NW'(pop);
    rem_d  = start ? start_count : (rem_q - CW'(add));
    free_d = NW'(DEPTH) - cnt_d;
    req_d  = (rem_d != '0) && (req_q ? (free_d >= NW'(wb)) : (free_d > NW'(thr)));
    hold_d = xfer && !start && (rem_q == CW'(add));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rem_q  <= '0;
      wp_q   <= '0;
      rp_q   <= '0;
      req_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      rem_q  <= rem_d;
      req_q  <= req_d;
      hold_q <= hold_d;
      if (xfer) wp_q <= wp_q + AW'(take);
      if (pop)  rp_q <= rp_q + AW'(1);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < PORT_BYTES; i++) begin
      if (xfer && (3'(i) < take))
        mem[wp_q + AW'(i)] <= pdata[8*lane_of(big, wb, 2'(i)) +: 8];
    end
  end

  assign req_n      = !req_q;
  assign tc_n       = !(((rem_q != '0) && (rem_q <= CW'(wb))) || hold_q);
  assign core_byte  = mem[rp_q];
  assign core_valid = cnt_q != '0;
  assign core_last  = (cnt_q == NW'(1)) && (rem_q == '0);
endmodule

// File: rtl/dbf_dst_side.sv
module dbf_dst_side
  import dbf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int TW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wide,
  input  logic          big,
  input  logic [TW-1:0] thr,
  input  logic [7:0]    core_byte,
  input  logic          core_valid,
  input  logic          core_last,
  output logic          core_ready,
  input  logic          ack_n,
  output logic          req_n,
  output logic [31:0]   pdata,
  output logic          tc_n,
  output logic          noalign,
  output logic          unf
);
  localparam int AW = $clog2(DEPTH);
  localparam int NW = AW + 1;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [NW-1:0] cnt_q, cnt_d;
  logic          sealed_q, sealed_d, req_q, req_d, hold_q, hold_d;
  logic [2:0]    wb, take, sub;
  logic [1:0]    code_lane;
  logic          has_word, can_xfer, xfer, push, short_w;

  assign wb         = word_bytes(wide);
  assign has_word   = cnt_q >= NW'(wb);
  assign can_xfer   = has_word || (sealed_q && (cnt_q != '0));
  assign take       = has_word ? wb : cnt_q[2:0];
  assign xfer       = !ack_n && can_xfer;
  assign unf        = !ack_n && !can_xfer;
  assign core_ready = (cnt_q != NW'(DEPTH)) && !sealed_q;
  assign push       = core_valid && core_ready;
  assign sub        = xfer ? take : 3'd0;
  assign short_w    = sealed_q && (cnt_q != '0) && !has_word;
  assign code_lane  = big ? 2'(wb - 3'd1 - take) : 2'(wb - 3'd1);

  always_comb begin
    cnt_d    = cnt_q - NW'(sub) + NW'(push);
    sealed_d = (sealed_q && (cnt_d != '0)) || (push && core_last);
    req_d    = (sealed_d && (cnt_d != '0)) ||
               (req_q ? (cnt_d >= NW'(wb))
                      : ((cnt_d > NW'(thr)) && (cnt_d >= NW'(wb))));
    hold_d   = xfer && sealed_q && (cnt_q <= NW'(wb));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      wp_q     <= '0;
      rp_q     <= '0;
      sealed_q <= 1'b0;
      req_q    <= 1'b0;
      hold_q   <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      sealed_q <= sealed_d;
      req_q    <= req_d;
      hold_q   <= hold_d;
      if (push) wp_q <= wp_q + AW'(1);
      if (xfer) rp_q <= rp_q + AW'(take);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= core_byte;
  end

  always_comb begin
    pdata = '0;
    for (int k = 0; k < PORT_BYTES; k++) begin
      if (3'(k) < wb) begin
        if ({1'b0, lane_of(big, wb, 2'(k))} < take)
          pdata[8*k +: 8] = mem[rp_q + AW'(lane_of(big, wb, 2'(k)))];
        else if (short_w && (2'(k) == code_lane))
          pdata[8*k +: 8] = {6'b0, take[1:0]};
      end
    end
  end

  assign req_n   = !req_q;
  assign tc_n    = !((sealed_q && (cnt_q != '0) && (cnt_q <= NW'(wb))) || hold_q);
  assign noalign = short_w;
endmodule

// File: rtl/dma_bytefifo_ctl.sv
module dma_bytefifo_ctl #(
  parameter int DEPTH = 32,
  parameter int CW    = 16,
  parameter int TW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wide,
  input  logic          cfg_big,
  input  logic [TW-1:0] cfg_src_thr,
  input  logic [TW-1:0] cfg_dst_thr,
  input  logic          cmd_start,
  input  logic [CW-1:0] cmd_count,
  output logic          src_req_n,
  input  logic          src_ack_n,
  input  logic [31:0]   src_data,
  output logic          src_tc_n,
  output logic [7:0]    core_in_byte,
  output logic          core_in_valid,
  input  logic          core_in_ready,
  output logic          core_in_last,
  input  logic [7:0]    core_out_byte,
  input  logic          core_out_valid,
  input  logic          core_out_last,
  output logic          core_out_ready,
  output logic          dst_req_n,
  input  logic          dst_ack_n,
  output logic [31:0]   dst_data,
  output logic          dst_tc_n,
  output logic          dst_noalign,
  output logic          data_err
);
  logic src_ovf, dst_unf, err_q, err_d;

  dbf_src_side #(.DEPTH(DEPTH), .CW(CW), .TW(TW)) u_src (
    .clk(clk), .rst_n(rst_n), .wide(cfg_wide), .big(cfg_big), .thr(cfg_src_thr),
    .start(cmd_start), .start_count(cmd_count), .ack_n(src_ack_n), .pdata(src_data),
    .req_n(src_req_n), .tc_n(src_tc_n), .ovf(src_ovf), .core_byte(core_in_byte),
    .core_valid(core_in_valid), .core_ready(core_in_ready), .core_last(core_in_last)
  );

  dbf_dst_side #(.DEPTH(DEPTH), .TW(TW)) u_dst (
    .clk(clk), .rst_n(rst_n), .wide(cfg_wide), .big(cfg_big), .thr(cfg_dst_thr),
    .core_byte(core_out_byte), .core_valid(core_out_valid), .core_last(core_out_last),
    .core_ready(core_out_ready), .ack_n(dst_ack_n), .req_n(dst_req_n),
    .pdata(dst_data), .tc_n(dst_tc_n), .noalign(dst_noalign), .unf(dst_unf)
  );

  assign err_d = src_ovf || dst_unf || (err_q && !cmd_start);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign data_err = err_q;
endmodule

// File: rtl/dma_bytefifo_chk.sv
module dma_bytefifo_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_start,
  input logic src_req_n,
  input logic src_ack_n,
  input logic core_in_valid,
  input logic core_in_last,
  input logic core_out_ready,
  input logic dst_req_n,
  input logic dst_ack_n,
  input logic dst_tc_n,
  input logic dst_noalign,
  input logic data_err
);
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_idle_in_reset: assert (src_req_n && dst_req_n && !data_err && !core_in_valid);
    end
  end

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (data_err && !cmd_start) |=> data_err);

  a_r8_noalign_has_tc: assert property (@(posedge clk) disable iff (!rst_n)
    dst_noalign |-> !dst_tc_n);

  a_r11_last_implies_valid: assert property (@(posedge clk) disable iff (!rst_n)
    core_in_last |-> core_in_valid);

  a_r11_closed_while_short: assert property (@(posedge clk) disable iff (!rst_n)
    dst_noalign |-> !core_out_ready);

  a_r6_granted_req_is_safe: assert property (@(posedge clk) disable iff (!rst_n)
    (!dst_req_n && !dst_ack_n && src_ack_n && !data_err) |=> !data_err);
endmodule

bind dma_bytefifo_ctl dma_bytefifo_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .src_req_n(src_req_n),
  .src_ack_n(src_ack_n), .core_in_valid(core_in_valid), .core_in_last(core_in_last),
  .core_out_ready(core_out_ready), .dst_req_n(dst_req_n), .dst_ack_n(dst_ack_n),
  .dst_tc_n(dst_tc_n), .dst_noalign(dst_noalign), .data_err(data_err)
);

// File: tb/dma_bytefifo_ctl_test.sv
`timescale 1ns/1ps
module dma_bytefifo_ctl_test;
  logic clk, rst_n;
  logic cfg_wide, cfg_big, cmd_start;
  logic [4:0] cfg_src_thr, cfg_dst_thr;
  logic [15:0] cmd_count;
  logic src_req_n, src_ack_n, src_tc_n;
  logic [31:0] src_data, dst_data;
  logic [7:0] core_in_byte, core_out_byte;
  logic core_in_valid, core_in_ready, core_in_last;
  logic core_out_valid, core_out_last, core_out_ready;
  logic dst_req_n, dst_ack_n, dst_tc_n, dst_noalign, data_err;

  dma_bytefifo_ctl uut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0, wd = 0;
  bit src_ack_en, dst_ack_en, force_src, force_dst, cin_en, cout_en, slow_core;
  byte unsigned sq[$], dq[$], cq[$];
  int srem;
  bit sreq, shold, dreq, dhold, dsealed, merr;

  task automatic chk(input string tag, input string name, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h (cycle %0d)", tag, name, act, exp, cyc);
    end
  endtask

  function automatic int wbytes();
    return cfg_wide ? 4 : 2;
  endfunction

  function automatic logic [31:0] exp_word();
    int W, n, cl, p;
    logic [31:0] w;
    W = wbytes();
    n = (dq.size() < W) ? dq.size() : W;
    cl = cfg_big ? W - 1 - n : W - 1;
    w = '0;
    for (int lane = 0; lane < W; lane++) begin
      p = cfg_big ? W - 1 - lane : lane;
      if (p < n) w[8*lane +: 8] = dq[p];
      else if (dsealed && n < W && lane == cl) w[8*lane +: 8] = 8'(n);
    end
    return w;
  endfunction

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    int W, sfree, st, dn, dt;
    bit sx, se, spop, dcan, dx, de, mrdy, dpush;
    if (!rst_n) begin
      sq.delete(); dq.delete();
      srem = 0; sreq = 0; shold = 0; dreq = 0; dhold = 0; dsealed = 0; merr = 0;
    end else begin
      W = wbytes();
      sfree = 32 - sq.size();
      sx = !src_ack_n && srem > 0 && sfree >= W;
      se = !src_ack_n && sfree < W;
      st = sx ? ((srem < W) ? srem : W) : 0;
      spop = sq.size() > 0 && core_in_ready;
      dn = dq.size();
      dcan = dn >= W || (dsealed && dn > 0);
      dx = !dst_ack_n && dcan;
      de = !dst_ack_n && !dcan;
      dt = dx ? ((dn < W) ? dn : W) : 0;
      mrdy = dn < 32 && !dsealed;
      dpush = core_out_valid && mrdy;
      shold = sx && !cmd_start && srem == st;
      dhold = dx && dsealed && dn <= W;
      if (spop) void'(sq.pop_front());
      for (int p = 0; p < st; p++) sq.push_back(src_data[8*(cfg_big ? W - 1 - p : p) +: 8]);
      srem = cmd_start ? int'(cmd_count) : srem - st;
      sreq = srem > 0 && (sreq ? (32 - sq.size()) >= W : (32 - sq.size()) > int'(cfg_src_thr));
      for (int p = 0; p < dt; p++) void'(dq.pop_front());
      if (dpush) begin
        dq.push_back(core_out_byte);
        if (core_out_last) dsealed = 1;
        void'(cq.pop_front());
      end
      if (dsealed && dq.size() == 0) dsealed = 0;
      dreq = (dsealed && dq.size() > 0) ||
             (dreq ? dq.size() >= W : (dq.size() > int'(cfg_dst_thr) && dq.size() >= W));
      merr = se || de || (merr && !cmd_start);
    end
  end

  // compare on falling edge, then drive handshake inputs
  always @(negedge clk) begin
    int W;
    cyc++;
    W = wbytes();
    if (rst_n) begin
      chk("R2", "src_req_n", src_req_n, !sreq);
      chk("R4", "src_tc_n", src_tc_n, !((srem > 0 && srem <= W) || shold));
      chk("R3", "core_in_valid", core_in_valid, sq.size() > 0);
      if (sq.size() > 0) chk("R5", "core_in_byte", core_in_byte, sq[0]);
      chk("R11", "core_in_last", core_in_last, sq.size() == 1 && srem == 0);
      chk("R11", "core_out_ready", core_out_ready, dq.size() < 32 && !dsealed);
      chk(dsealed ? "R7" : "R6", "dst_req_n", dst_req_n, !dreq);
      chk("R9", "dst_tc_n", dst_tc_n, !((dsealed && dq.size() > 0 && dq.size() <= W) || dhold));
      chk("R8", "dst_noalign", dst_noalign, dsealed && dq.size() > 0 && dq.size() < W);
      if (dq.size() >= W || (dsealed && dq.size() > 0))
        chk("R8", "dst_data", dst_data, exp_word());
      chk("R10", "data_err", data_err, merr);
    end
    src_ack_n = !(force_src || (src_ack_en && !src_req_n && (cyc % 4 != 2)));
    src_data = $urandom;
    core_in_ready = cin_en && (!slow_core || (cyc % 4 == 0));
    dst_ack_n = !(force_dst || (dst_ack_en && !dst_req_n && (cyc % 3 != 1)));
    core_out_valid = cout_en && cq.size() > 0 && (cyc % 5 != 4);
    core_out_byte = (cq.size() > 0) ? cq[0] : 8'h00;
    core_out_last = cq.size() == 1;
  end

  always @(posedge clk) begin
    wd++;
    if (wd == 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic bit idle();
    return srem == 0 && sq.size() == 0 && dq.size() == 0 && cq.size() == 0 && !dsealed;
  endfunction

  task automatic wait_idle();
    for (int i = 0; i < 3000 && !idle(); i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic set_cfg(input bit wide, input bit big, input int sthr, input int dthr);
    @(negedge clk);
    cfg_wide = wide; cfg_big = big;
    cfg_src_thr = 5'(sthr); cfg_dst_thr = 5'(dthr);
  endtask

  task automatic start_cmd(input int n);
    @(negedge clk);
    cmd_start = 1'b1; cmd_count = 16'(n);
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic load_out(input int n, input int seed);
    for (int i = 0; i < n; i++) cq.push_back(8'(seed + 13 * i));
  endtask

  initial begin
    rst_n = 1'b0; cmd_start = 1'b0; cmd_count = '0;
    cfg_wide = 1'b1; cfg_big = 1'b0; cfg_src_thr = 5'd8; cfg_dst_thr = 5'd8;
    src_ack_n = 1'b1; dst_ack_n = 1'b1; src_data = '0;
    core_in_ready = 1'b0; core_out_valid = 1'b0; core_out_byte = '0; core_out_last = 1'b0;
    src_ack_en = 1; dst_ack_en = 1; cin_en = 1; cout_en = 1;
    force_src = 0; force_dst = 0; slow_core = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "src_req_n", src_req_n, 1);
    chk("R1", "dst_req_n", dst_req_n, 1);
    chk("R1", "src_tc_n", src_tc_n, 1);
    chk("R1", "dst_tc_n", dst_tc_n, 1);
    chk("R1", "data_err", data_err, 0);
    chk("R1", "core_in_valid", core_in_valid, 0);
    chk("R1", "core_out_ready", core_out_ready, 1);
    rst_n = 1'b1;

    // R3 R5: 32-bit little endian, 10 bytes (last word partly dropped)
    set_cfg(1, 0, 8, 8);  start_cmd(10); wait_idle();
    // R3 R5: 16-bit big endian, odd count
    set_cfg(0, 1, 4, 8);  start_cmd(7);  wait_idle();
    // R2: hysteresis with a slow engine, 60 bytes
    set_cfg(1, 0, 12, 8); slow_core = 1; start_cmd(60); wait_idle(); slow_core = 0;
    // R7 R8 R9: outbound block below threshold, little endian short word
    set_cfg(1, 0, 8, 20); load_out(10, 3); wait_idle();
    // R6 R8 R5: outbound 16-bit big endian, 21 bytes
    set_cfg(0, 1, 8, 6);  load_out(21, 40); wait_idle();
    // R8: 32-bit big endian, 3-byte tail
    set_cfg(1, 1, 8, 8);  load_out(11, 90); wait_idle();
    // concurrent traffic both ways
    set_cfg(1, 0, 8, 4);  load_out(37, 7); start_cmd(45); wait_idle();

    // R10: inbound acknowledge while full, then cleared by cmd_start
    set_cfg(1, 0, 12, 8); cin_en = 0; start_cmd(40);
    repeat (30) @(negedge clk);
    force_src = 1; @(negedge clk); force_src = 0;
    repeat (3) @(negedge clk);
    chk("R10", "data_err after full ack", data_err, 1);
    cin_en = 1; wait_idle();
    start_cmd(0); @(negedge clk);
    chk("R10", "data_err after start", data_err, 0);
    // R10: outbound acknowledge while empty
    force_dst = 1; @(negedge clk); force_dst = 0;
    repeat (2) @(negedge clk);
    chk("R10", "data_err after empty ack", data_err, 1);
    chk("R3", "no inbound data after error", core_in_valid, 0);
    start_cmd(0); wait_idle();

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule